// File: doc/BRIEF.md
# Randomized Line-Test Ping Scheduler

This block decides when and which signaling channel gets a liveness ping. It serves a set of alert receiver channels and a set of escalation sender channels. Between two ping slots it idles for a pseudo-random number of cycles drawn from an internal LFSR. The slots alternate between an alert slot and an escalation slot. In an alert slot, one alert channel is picked at random. In an escalation slot, the escalation channels are visited in strict rotation, so the spacing between pings of any one escalation line stays bounded.

A ping request is raised on exactly one channel and held until that channel acknowledges or the programmable timeout expires. A missing acknowledge produces a one-cycle failure pulse, with separate pulses for the alert side and the escalation side. An alert channel is never pinged if it is disabled or if its low-power group is clock-gated or held in reset. If the random draw hits such a channel, that slot is dropped without any failure. After a fixed number of completed escalation pings, the scheduler asks an external entropy source for a new LFSR seed and issues no pings until the seed arrives.

Top module: `ping_sched`

## Requirements
- R1: During and directly after reset, no ping request, failure pulse or seed request is asserted.
- R2: At most one ping request, alert or escalation, is high in any cycle, and a raised request stays on the same channel until it drops.
- R3: Between the drop of one ping request and the rise of the next there are at least MIN_WAIT idle cycles; the extra wait is taken from the LFSR.
- R4: Two alert pings never follow each other without an escalation ping between them; with every alert channel allowed, alert and escalation pings strictly alternate, starting with an alert slot.
- R5: Escalation pings visit channels 0, 1, ..., N_ESC-1 and then wrap to 0, starting from channel 0 after reset.
- R6: An alert channel whose enable bit is 0, or whose low-power group bit is 1 (alerts 0..N_ALERT/2-1 in group 0, the rest in group 1 by default), is never pinged, and a dropped slot raises no failure.
- R7: An acknowledge that arrives L cycles after the request rises, with L no greater than the timeout value, ends the request after L+1 cycles and raises no failure; L equal to the timeout still passes.
- R8: Without an acknowledge, the request stays high for timeout+1 cycles. The matching failure output (alert or escalation) is then high for exactly the one cycle after the request drops, and the other failure output stays low.
- R9: When the RESEED_PINGS-th escalation ping since the last reseed completes, the seed request rises in the cycle the ping request drops. It stays high with no ping issued until the seed acknowledge, on which the seed is loaded and the request drops.
- R10: Alert targets are chosen pseudo-randomly, so over many slots every allowed alert channel is pinged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alert_en_i | input | N_ALERT | Per alert channel enable |
| grp_lowpwr_i | input | N_GRP | Per low-power group: 1 when the group is clock-gated or in reset |
| timeout_i | input | TMO_W | Maximum acknowledge latency in cycles |
| seed_i | input | LFSR_W | New LFSR seed, taken when seed_ack_i is high |
| seed_ack_i | input | 1 | Seed valid strobe |
| seed_req_o | output | 1 | Request for a new seed |
| alert_ping_req_o | output | N_ALERT | Ping request per alert channel |
| alert_ping_ack_i | input | N_ALERT | Ping acknowledge per alert channel |
| esc_ping_req_o | output | N_ESC | Ping request per escalation channel |
| esc_ping_ack_i | input | N_ESC | Ping acknowledge per escalation channel |
| alert_fail_o | output | 1 | One-cycle pulse on an alert ping timeout |
| esc_fail_o | output | 1 | One-cycle pulse on an escalation ping timeout |

## Verification
The embedded properties assume that the enable and low-power inputs may change at any time, but that a channel's eligibility is judged in the cycle before its request rises. They also assume that acknowledges matter only on the currently requested channel. The stimulus changes enables, group masks and acknowledge latency only while the scheduler waits for a seed, so each phase runs under one fixed configuration. A responder acknowledges every request after a set latency, and a scoreboard predicts how long each request stays high and whether a failure pulse follows. The phases cover all channels allowed, a partial mask, acknowledges later than the timeout, latency equal to and one above the timeout, and all alert channels disabled.

// File: rtl/ping_sched.sv
module ping_sched #(
  parameter int N_ALERT      = 8,
  parameter int N_ESC        = 4,
  parameter int N_GRP        = 2,
  parameter int GRP_W        = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  parameter logic [N_ALERT*GRP_W-1:0] GRP_MAP =
    {{(N_ALERT/2*GRP_W){1'b1}}, {((N_ALERT-N_ALERT/2)*GRP_W){1'b0}}},
  parameter int LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter int WAIT_W       = 4,
  parameter int MIN_WAIT     = 4,
  parameter int TMO_W        = 8,
  parameter int RESEED_PINGS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_ALERT-1:0] alert_en_i,
  input  logic [N_GRP-1:0]   grp_lowpwr_i,
  input  logic [TMO_W-1:0]   timeout_i,
  input  logic [LFSR_W-1:0]  seed_i,
  input  logic               seed_ack_i,
  output logic               seed_req_o,
  output logic [N_ALERT-1:0] alert_ping_req_o,
  input  logic [N_ALERT-1:0] alert_ping_ack_i,
  output logic [N_ESC-1:0]   esc_ping_req_o,
  input  logic [N_ESC-1:0]   esc_ping_ack_i,
  output logic               alert_fail_o,
  output logic               esc_fail_o
);
  localparam int IDX_W  = (N_ALERT > 1) ? $clog2(N_ALERT) : 1;
  localparam int NPAD   = 1 << IDX_W;
  localparam int ESC_W  = (N_ESC > 1) ? $clog2(N_ESC) : 1;
  localparam int RCNT_W = $clog2(RESEED_PINGS + 1);
  localparam int WCNT_W = $clog2(MIN_WAIT + (1 << WAIT_W)) + 1;

  typedef enum logic [1:0] {S_WAIT, S_PING, S_SEED} state_e;

  state_e            st;
  logic [LFSR_W-1:0] lfsr;
  logic [WCNT_W-1:0] wcnt;
  logic [TMO_W-1:0]  tcnt;
  logic              turn_esc;
  logic [IDX_W-1:0]  a_idx;
  logic [ESC_W-1:0]  e_idx;
  logic [RCNT_W-1:0] rcnt;
  logic              a_fail_q, e_fail_q;
  logic [N_ALERT-1:0] a_ok;
  logic [NPAD-1:0]   a_ok_pad;

  for (genvar i = 0; i < N_ALERT; i++) begin : g_ok
    assign a_ok[i] = alert_en_i[i] & ~grp_lowpwr_i[GRP_MAP[i*GRP_W +: GRP_W]];
  end
  assign a_ok_pad = NPAD'(a_ok);

  wire [IDX_W-1:0]  pick     = lfsr[WAIT_W +: IDX_W];
  wire              pick_ok  = a_ok_pad[pick];
  wire [WCNT_W-1:0] wait_ld  = WCNT_W'(MIN_WAIT) + WCNT_W'(lfsr[WAIT_W-1:0]);
  wire [LFSR_W-1:0] lfsr_nx  = {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? TAPS : '0);
  wire              acked    = turn_esc ? esc_ping_ack_i[e_idx] : alert_ping_ack_i[a_idx];
  wire              expired  = (tcnt == timeout_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= S_WAIT;
      lfsr     <= LFSR_W'(1);
      wcnt     <= WCNT_W'(MIN_WAIT);
      tcnt     <= '0;
      turn_esc <= 1'b0;
      a_idx    <= '0;
      e_idx    <= '0;
      rcnt     <= '0;
      a_fail_q <= 1'b0;
      e_fail_q <= 1'b0;
    end else begin
      lfsr     <= lfsr_nx;
      a_fail_q <= 1'b0;
      e_fail_q <= 1'b0;
      case (st)
        S_WAIT: begin
          if (wcnt != '0) begin
            wcnt <= wcnt - WCNT_W'(1);
          end else if (turn_esc) begin
            st   <= S_PING;
            tcnt <= '0;
          end else if (pick_ok) begin
            a_idx <= pick;
            st    <= S_PING;
            tcnt  <= '0;
          end else begin
            turn_esc <= 1'b1;
            wcnt     <= wait_ld;
          end
        end
        S_PING: begin
          if (acked || expired) begin
            if (!acked) begin
              if (turn_esc) e_fail_q <= 1'b1;
              else          a_fail_q <= 1'b1;
            end
            turn_esc <= ~turn_esc;
            wcnt     <= wait_ld;
            st       <= S_WAIT;
            if (turn_esc) begin
              e_idx <= (e_idx == ESC_W'(N_ESC-1)) ? '0 : e_idx + ESC_W'(1);
              if (rcnt == RCNT_W'(RESEED_PINGS-1)) begin
                rcnt <= '0;
                st   <= S_SEED;
              end else begin
                rcnt <= rcnt + RCNT_W'(1);
              end
            end
          end else begin
            tcnt <= tcnt + TMO_W'(1);
          end
        end
        default: begin
          if (seed_ack_i) begin
            lfsr <= (seed_i == '0) ? LFSR_W'(1) : seed_i;
            wcnt <= wait_ld;
            st   <= S_WAIT;
          end
        end
      endcase
    end
  end

  assign alert_ping_req_o = (st == S_PING && !turn_esc) ? (N_ALERT'(1) << a_idx) : '0;
  assign esc_ping_req_o   = (st == S_PING &&  turn_esc) ? (N_ESC'(1) << e_idx) : '0;
  assign seed_req_o       = (st == S_SEED);
  assign alert_fail_o     = a_fail_q;
  assign esc_fail_o       = e_fail_q;

  assert_one_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({alert_ping_req_o, esc_ping_req_o}));

  assert_req_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{alert_ping_req_o, esc_ping_req_o}) |=>
      (!(|{alert_ping_req_o, esc_ping_req_o}) || $stable({alert_ping_req_o, esc_ping_req_o})));

  assert_seed_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seed_req_o |-> !(|{alert_ping_req_o, esc_ping_req_o}));

  assert_afail_after_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_fail_o |-> ($past(|alert_ping_req_o) && !(|alert_ping_req_o) && !esc_fail_o));

  assert_efail_after_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_fail_o |-> ($past(|esc_ping_req_o) && !(|esc_ping_req_o)));

  for (genvar i = 0; i < N_ALERT; i++) begin : g_chk
    assert_masked_never_pinged_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(alert_ping_req_o[i]) |-> $past(a_ok[i]));
  end
endmodule

// File: tb/test_ping_sched.sv
`timescale 1ns/100ps
module test_ping_sched;
  localparam int NA = 8, NE = 4, TMO = 6, K = 8, MINW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic [NA-1:0] en;
  logic [1:0]    lp;
  logic [7:0]    tmo;
  logic [15:0]   seed;
  logic          seed_ack;
  logic          seed_req;
  logic [NA-1:0] a_req, a_ack;
  logic [NE-1:0] e_req, e_ack;
  logic          a_fail, e_fail;

  ping_sched i_ping_sched (
    .clk_i(clk), .rst_ni(rst_n), .alert_en_i(en), .grp_lowpwr_i(lp),
    .timeout_i(tmo), .seed_i(seed), .seed_ack_i(seed_ack), .seed_req_o(seed_req),
    .alert_ping_req_o(a_req), .alert_ping_ack_i(a_ack),
    .esc_ping_req_o(e_req), .esc_ping_ack_i(e_ack),
    .alert_fail_o(a_fail), .esc_fail_o(e_fail));

  int checks = 0, errors = 0;
  int lat = 2;
  bit strict = 1'b1;
  bit run = 1'b0;
  bit done = 1'b0;
  logic [NA-1:0] cov = '0;
  int exp_q[$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // responder: acknowledges each request after lat cycles, pushes the expectation
  initial begin
    int cnt [NA+NE];
    logic [NA+NE-1:0] r;
    foreach (cnt[i]) cnt[i] = 0;
    a_ack = '0; e_ack = '0;
    forever begin
      @(negedge clk);
      r = {e_req, a_req};
      for (int i = 0; i < NA + NE; i++) begin
        if (r[i]) begin
          if (cnt[i] == 0) exp_q.push_back(lat);
          if (i < NA) a_ack[i] = (cnt[i] >= lat);
          else        e_ack[i-NA] = (cnt[i] >= lat);
          cnt[i]++;
        end else begin
          if (i < NA) a_ack[i] = 1'b0;
          else        e_ack[i-NA] = 1'b0;
          cnt[i] = 0;
        end
      end
    end
  end

  // monitor / scoreboard
  initial begin
    logic [NA+NE-1:0] prev, cur;
    int hold, gap, esc_exp, last_kind, esc_done, idx, l, fl;
    bit first, expf;
    prev = '0; hold = 0; gap = 0; esc_exp = 0; last_kind = 0; esc_done = 0; first = 1'b1;
    wait (run);
    forever begin
      @(negedge clk);
      cur = {e_req, a_req};
      if (cur != '0 && prev == '0) begin
        chk($onehot(cur), "R2 single request", $countones(cur), 1);
        chk(!seed_req, "R9 no ping during reseed", seed_req, 0);
        if (!first) chk(gap >= MINW, "R3 idle gap", gap, MINW);
        first = 1'b0;
        if (a_req != '0) begin
          idx = 0;
          for (int i = 0; i < NA; i++) if (a_req[i]) idx = i;
          chk(en[idx] && !lp[idx / (NA/2)], "R6 allowed target", idx, -1);
          cov[idx] = 1'b1;
          chk(last_kind != 1, "R4 no back-to-back alert pings", last_kind, 2);
          last_kind = 1;
        end else begin
          idx = 0;
          for (int i = 0; i < NE; i++) if (e_req[i]) idx = i;
          chk(idx == esc_exp, "R5 escalation order", idx, esc_exp);
          if (strict) chk(last_kind != 2, "R4 strict alternation", last_kind, 1);
          esc_exp = (esc_exp + 1) % NE;
          last_kind = 2;
        end
        hold = 0;
      end
      if (prev != '0 && cur != '0)
        chk(cur == prev, "R2 request held on one channel", cur, prev);
      if (cur != '0) hold++;
      if (prev != '0 && cur == '0) begin
        l = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
        expf = (l > TMO);
        fl = expf ? TMO + 1 : l + 1;
        chk(hold == fl, expf ? "R8 request length on timeout" : "R7 request length on ack", hold, fl);
        if (prev[NA +: NE] != '0) begin
          chk(e_fail == expf && !a_fail, expf ? "R8 esc fail pulse" : "R7 no esc fail",
              {a_fail, e_fail}, {1'b0, expf});
          esc_done++;
          chk(seed_req == (esc_done % K == 0), "R9 seed request timing", seed_req, (esc_done % K == 0));
        end else begin
          chk(a_fail == expf && !e_fail, expf ? "R8 alert fail pulse" : "R7 no alert fail",
              {a_fail, e_fail}, {expf, 1'b0});
        end
        gap = 0;
      end else begin
        chk(!a_fail && !e_fail, "R8 fail only after a request", {a_fail, e_fail}, 0);
      end
      if (cur == '0) gap++;
      prev = cur;
    end
  end

  task automatic reseed(input int n, input logic [NA-1:0] n_en, input logic [1:0] n_lp,
                        input int n_lat, input bit n_strict, input bit clr_cov);
    while (!seed_req) @(negedge clk);
    en = n_en; lp = n_lp; lat = n_lat; strict = n_strict;
    if (clr_cov) cov = '0;
    repeat (3) @(negedge clk);
    seed = 16'hACE1 ^ 16'(n * 971);
    seed_ack = 1'b1;
    @(negedge clk);
    seed_ack = 1'b0;
    chk(!seed_req, "R9 seed request drops on ack", seed_req, 0);
  endtask

  initial begin
    rst_n = 1'b0; en = '1; lp = '0; tmo = 8'(TMO); seed = '0; seed_ack = 1'b0;
    repeat (4) @(negedge clk);
    chk(a_req == '0 && e_req == '0, "R1 no request in reset", {e_req, a_req}, 0);
    chk(!a_fail && !e_fail && !seed_req, "R1 quiet in reset", {seed_req, a_fail, e_fail}, 0);
    rst_n = 1'b1;
    run = 1'b1;
    @(negedge clk);
    chk(a_req == '0 && e_req == '0 && !seed_req, "R1 quiet after reset", {seed_req, e_req, a_req}, 0);
    // phase A: everything allowed, fast acknowledges, strict alternation
    for (int n = 0; n < 10; n++) reseed(n, '1, 2'b00, 2, 1'b1, 1'b0);
    chk(cov == '1, "R10 all alert channels pinged", cov, 8'hFF);
    // phase B: alert 1 disabled, group 1 (alerts 4..7) in low power
    for (int n = 10; n < 18; n++) reseed(n, 8'b1111_1101, 2'b10, 3, 1'b0, n == 10);
    reseed(18, '1, 2'b00, 20, 1'b1, 1'b0);
    chk(cov == 8'b0000_1101, "R6 only allowed channels pinged", cov, 8'b0000_1101);
    // phase C: acknowledges far too late, every ping fails
    reseed(19, '1, 2'b00, 20, 1'b1, 1'b0);
    // phase D: latency exactly at and just beyond the timeout
    reseed(20, '1, 2'b00, TMO, 1'b1, 1'b0);
    reseed(21, '1, 2'b00, TMO + 1, 1'b1, 1'b0);
    // phase E: no alert channel enabled, only escalation pings
    reseed(22, '0, 2'b00, 1, 1'b0, 1'b1);
    reseed(23, '1, 2'b00, 1, 1'b0, 1'b0);
    chk(cov == '0, "R6 disabled channels never pinged", cov, 0);
    repeat (20) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end
endmodule